// File: doc/BRIEF.md
# Device Interrupt-Service Responder

This block is the device end of an interrupt-service exchange on a shared tag bus. A local pulse registers an interrupt request, along with a condition code and a data word that the device will hand back. The request is shown on a request line. The host then serves the interrupt. It places an address on the address bus and asserts a service-active tag. If the address names this device and a request is pending, the device raises select response and drives the stored condition code and data onto its return lines.

The host then pulses a strobe. The leading edge of the strobe retires the pending request. Select response and the returned values stay in place until service-active is withdrawn, and they are then released together. The service-active and strobe tags come from another timing domain, so both pass through a synchronizer before any decision is made on them. If a new request pulse arrives while an exchange is in progress, it is held back. It is posted as soon as that exchange ends.

Top module: `isvc_responder`

## Requirements
- R1: After reset, sel_resp, irq_req, cc_in and data_in are all zero.
- R2: A one-cycle irq_set pulse while no exchange is in progress sets irq_req on the next clock edge and stores irq_cc and irq_data; a later pulse before service replaces the stored values.
- R3: sel_resp rises on the third clock edge after svc_active is first seen high, but only if bus_addr equals the DEV_ADDR parameter and a request is pending.
- R4: With a mismatched address, or with no pending request, sel_resp stays low for as long as svc_active is held.
- R5: While sel_resp is high, cc_in and data_in hold the values that were stored when selection happened, unchanged; while sel_resp is low they are zero.
- R6: When strobe rises while the device is selected, irq_req falls on the third clock edge after the rising edge of strobe, and sel_resp stays high.
- R7: sel_resp, cc_in and data_in stay asserted while svc_active is high, and all three return to zero on the third clock edge after svc_active falls.
- R8: An irq_set pulse during an exchange does not change irq_req or the returned values; it sets irq_req again, with the new code and data, on the edge where the exchange ends.
- R9: A strobe that arrives while the device is not selected leaves irq_req unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_set | input | 1 | One-cycle pulse that posts an interrupt request |
| irq_cc | input | CC_W | Condition code to return, sampled with irq_set |
| irq_data | input | DATA_W | Data word to return, sampled with irq_set |
| bus_addr | input | ADDR_W | Device address presented by the host |
| svc_active | input | 1 | Service-active tag (asynchronous) |
| strobe | input | 1 | Strobe tag (asynchronous) |
| sel_resp | output | 1 | Select response tag |
| cc_in | output | CC_W | Returned condition code, zero when not selected |
| data_in | output | DATA_W | Returned data word, zero when not selected |
| irq_req | output | 1 | Pending interrupt request line |

## Verification
Each tag input passes through two synchronizer stages and then one decision register. A change on svc_active or strobe therefore reaches sel_resp, the return lines or irq_req on the third clock edge after it is applied. A request pulse reaches irq_req on the first clock edge. The bench drives every input on the falling clock edge and counts rising edges from that point. It samples on the falling edge, which keeps each directed check in the exact cycle where its result is due. A behavioural model in the bench delays the tags by the same two stages and is compared with all four outputs on every falling edge. This also covers the cycles just before each transition.

// File: rtl/isvc_pkg.sv
`timescale 1ns/1ps
package isvc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEL  = 1'b1
  } sel_state_e;
endpackage

// File: rtl/isvc_sync.sv
`timescale 1ns/1ps
// Multi-bit, per-bit flop-chain synchronizer for asynchronous tag inputs.
module isvc_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) begin
          chain <= '0;
        end else begin
          chain[0] <= d[b];
          for (int s = 1; s < STAGES; s++) begin
            chain[s] <= chain[s-1];
          end
        end
      end
      assign q[b] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/isvc_pending.sv
`timescale 1ns/1ps
// Pending request, stored return values and a one-entry deferral slot.
module isvc_pending #(
  parameter int CC_W   = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set,
  input  logic [CC_W-1:0]   set_cc,
  input  logic [DATA_W-1:0] set_data,
  input  logic              busy,
  input  logic              exit_evt,
  input  logic              clr,
  output logic              pend,
  output logic [CC_W-1:0]   hold_cc,
  output logic [DATA_W-1:0] hold_data
);
  logic              q_valid;
  logic [CC_W-1:0]   q_cc;
  logic [DATA_W-1:0] q_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      hold_cc   <= '0;
      hold_data <= '0;
      q_valid   <= 1'b0;
      q_cc      <= '0;
      q_data    <= '0;
    end else if (exit_evt) begin
      if (clr) pend <= 1'b0;
      if (set) begin
        pend      <= 1'b1;
        hold_cc   <= set_cc;
        hold_data <= set_data;
      end else if (q_valid) begin
        pend      <= 1'b1;
        hold_cc   <= q_cc;
        hold_data <= q_data;
      end
      q_valid <= 1'b0;
    end else if (busy) begin
      if (clr) pend <= 1'b0;
      if (set) begin
        q_valid <= 1'b1;
        q_cc    <= set_cc;
        q_data  <= set_data;
      end
    end else if (set) begin
      pend      <= 1'b1;
      hold_cc   <= set_cc;
      hold_data <= set_data;
    end
  end

  // R8: a deferred request is posted when the exchange closes
  p_queue_reraise_r8: assert property (@(posedge clk) disable iff (rst)
    (exit_evt && q_valid) |=> pend);
endmodule

// File: rtl/isvc_select.sv
`timescale 1ns/1ps
// Selection state, registered return lines and strobe edge detection.
module isvc_select #(
  parameter int CC_W   = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              svc_s,
  input  logic              stb_s,
  input  logic              addr_hit,
  input  logic              pend,
  input  logic [CC_W-1:0]   hold_cc,
  input  logic [DATA_W-1:0] hold_data,
  output logic              sel,
  output logic [CC_W-1:0]   cc_o,
  output logic [DATA_W-1:0] data_o,
  output logic              busy,
  output logic              exit_evt,
  output logic              clr
);
  import isvc_pkg::*;

  sel_state_e state;
  logic       stb_prev;

  assign busy     = (state == ST_SEL);
  assign exit_evt = busy && !svc_s;
  assign clr      = busy && stb_s && !stb_prev;
  assign sel      = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cc_o     <= '0;
      data_o   <= '0;
      stb_prev <= 1'b0;
    end else begin
      stb_prev <= stb_s;
      case (state)
        ST_IDLE: if (svc_s && addr_hit && pend) begin
          state  <= ST_SEL;
          cc_o   <= hold_cc;
          data_o <= hold_data;
        end
        ST_SEL: if (!svc_s) begin
          state  <= ST_IDLE;
          cc_o   <= '0;
          data_o <= '0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: returned values are frozen for the whole selection
  p_stable_return_r5: assert property (@(posedge clk) disable iff (rst)
    (sel && $past(sel)) |-> ($stable(cc_o) && $stable(data_o)));
endmodule

// File: rtl/isvc_responder.sv
`timescale 1ns/1ps
module isvc_responder #(
  parameter int                 ADDR_W      = 8,
  parameter int                 CC_W        = 4,
  parameter int                 DATA_W      = 16,
  parameter int                 SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0]  DEV_ADDR    = 8'h2A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_set,
  input  logic [CC_W-1:0]   irq_cc,
  input  logic [DATA_W-1:0] irq_data,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              svc_active,
  input  logic              strobe,
  output logic              sel_resp,
  output logic [CC_W-1:0]   cc_in,
  output logic [DATA_W-1:0] data_in,
  output logic              irq_req
);
  localparam int TAG_W = 2;

  logic [TAG_W-1:0]  tag_s;
  logic              svc_s, stb_s, addr_hit;
  logic              busy, exit_evt, clr, pend;
  logic [CC_W-1:0]   hold_cc;
  logic [DATA_W-1:0] hold_data;

  isvc_sync #(.WIDTH(TAG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({strobe, svc_active}), .q(tag_s));

  assign svc_s    = tag_s[0];
  assign stb_s    = tag_s[1];
  assign addr_hit = (bus_addr == DEV_ADDR);

  isvc_pending #(.CC_W(CC_W), .DATA_W(DATA_W)) u_pend (
    .clk(clk), .rst(rst), .set(irq_set), .set_cc(irq_cc), .set_data(irq_data),
    .busy(busy), .exit_evt(exit_evt), .clr(clr),
    .pend(pend), .hold_cc(hold_cc), .hold_data(hold_data));

  isvc_select #(.CC_W(CC_W), .DATA_W(DATA_W)) u_sel (
    .clk(clk), .rst(rst), .svc_s(svc_s), .stb_s(stb_s), .addr_hit(addr_hit),
    .pend(pend), .hold_cc(hold_cc), .hold_data(hold_data),
    .sel(sel_resp), .cc_o(cc_in), .data_o(data_in),
    .busy(busy), .exit_evt(exit_evt), .clr(clr));

  assign irq_req = pend;

  // R3: selection only follows a synchronized service tag, a hit and a request
  p_rise_needs_match_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_resp) |-> $past(svc_s && addr_hit && pend));

  // R4: no hit or nothing pending keeps the device deselected
  p_no_hit_no_sel_r4: assert property (@(posedge clk) disable iff (rst)
    (!sel_resp && !(addr_hit && pend)) |=> !sel_resp);

  // R7: select response is held while service-active is seen
  p_hold_while_svc_r7: assert property (@(posedge clk) disable iff (rst)
    (sel_resp && svc_s) |=> sel_resp);

  // R6: strobe leading edge retires the request
  p_strobe_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (clr && svc_s && !irq_set) |=> !irq_req);
endmodule

// File: tb/isvc_responder_bench.sv
`timescale 1ns/1ps
module isvc_responder_bench;
  localparam int AW = 8, CW = 4, DW = 16;
  localparam logic [AW-1:0] DEV = 8'h2A;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          irq_set = 1'b0;
  logic [CW-1:0] irq_cc = '0;
  logic [DW-1:0] irq_data = '0;
  logic [AW-1:0] bus_addr = '0;
  logic          svc_active = 1'b0, strobe = 1'b0;
  logic          sel_resp, irq_req;
  logic [CW-1:0] cc_in;
  logic [DW-1:0] data_in;

  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  isvc_responder #(.ADDR_W(AW), .CC_W(CW), .DATA_W(DW), .DEV_ADDR(DEV)) u_isvc_responder (
    .clk(clk), .rst(rst), .irq_set(irq_set), .irq_cc(irq_cc), .irq_data(irq_data),
    .bus_addr(bus_addr), .svc_active(svc_active), .strobe(strobe),
    .sel_resp(sel_resp), .cc_in(cc_in), .data_in(data_in), .irq_req(irq_req));

  // behavioural reference model
  bit      m_svc[$], m_stb[$];
  bit      m_stbp, m_pend, m_sel, m_q;
  int      m_hcc, m_hdat, m_qcc, m_qdat, m_occ, m_odat;

  always @(posedge clk) begin
    if (rst) begin
      m_svc = {0, 0}; m_stb = {0, 0};
      m_stbp = 0; m_pend = 0; m_sel = 0; m_q = 0;
      m_hcc = 0; m_hdat = 0; m_qcc = 0; m_qdat = 0; m_occ = 0; m_odat = 0;
    end else begin
      automatic bit sv = m_svc[0];
      automatic bit st = m_stb[0];
      automatic bit rise = st && !m_stbp;
      automatic bit was_sel = m_sel;
      automatic int hcc = m_hcc, hdat = m_hdat;
      if (was_sel && !sv) begin
        if (rise) m_pend = 0;
        if (irq_set) begin m_pend = 1; m_hcc = irq_cc; m_hdat = irq_data; end
        else if (m_q) begin m_pend = 1; m_hcc = m_qcc; m_hdat = m_qdat; end
        m_q = 0;
        m_sel = 0; m_occ = 0; m_odat = 0;
      end else if (was_sel) begin
        if (rise) m_pend = 0;
        if (irq_set) begin m_q = 1; m_qcc = irq_cc; m_qdat = irq_data; end
      end else begin
        if (sv && bus_addr == DEV && m_pend) begin
          m_sel = 1; m_occ = hcc; m_odat = hdat;
        end
        if (irq_set) begin m_pend = 1; m_hcc = irq_cc; m_hdat = irq_data; end
      end
      m_stbp = st;
      void'(m_svc.pop_front()); m_svc.push_back(svc_active);
      void'(m_stb.pop_front()); m_stb.push_back(strobe);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    chk("R3 model sel_resp", sel_resp, m_sel);
    chk("R5 model cc_in", cc_in, m_occ);
    chk("R5 model data_in", data_in, m_odat);
    chk("R6 model irq_req", irq_req, m_pend);
  end

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_set(input int cc, input int dat);
    irq_cc = CW'(cc); irq_data = DW'(dat); irq_set = 1;
    @(negedge clk); irq_set = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    edges(3); rst = 0; @(negedge clk);
    chk("R1 sel", sel_resp, 0); chk("R1 irq", irq_req, 0);
    chk("R1 cc", cc_in, 0); chk("R1 data", data_in, 0);

    pulse_set(5, 16'h1111);
    chk("R2 irq set", irq_req, 1);
    pulse_set(3, 16'hBEEF);                   // R2 replacement before service
    bus_addr = DEV; svc_active = 1;
    edges(2); chk("R3 not yet", sel_resp, 0);
    edges(1); chk("R3 selected", sel_resp, 1);
    chk("R5 cc", cc_in, 3); chk("R2 R5 data", data_in, 16'hBEEF);
    edges(1); strobe = 1;
    edges(2); chk("R6 irq before", irq_req, 1);
    edges(1); chk("R6 irq cleared", irq_req, 0); chk("R6 sel held", sel_resp, 1);
    strobe = 0; edges(4);
    chk("R7 held", sel_resp, 1); chk("R5 data held", data_in, 16'hBEEF);
    svc_active = 0;
    edges(2); chk("R7 still held", sel_resp, 1);
    edges(1); chk("R7 sel drop", sel_resp, 0);
    chk("R7 cc drop", cc_in, 0); chk("R7 data drop", data_in, 0);
    bus_addr = 8'h00;

    pulse_set(9, 16'h1234);
    bus_addr = 8'h2B; svc_active = 1;
    edges(6); chk("R4 mismatch", sel_resp, 0); chk("R5 idle data", data_in, 0);
    strobe = 1; edges(4); strobe = 0;
    chk("R9 irq kept", irq_req, 1);
    svc_active = 0; edges(4);

    bus_addr = DEV; svc_active = 1;
    edges(3); chk("R3 second", sel_resp, 1); chk("R5 data2", data_in, 16'h1234);
    strobe = 1; edges(3); strobe = 0;
    chk("R6 second clear", irq_req, 0);
    pulse_set(7, 16'hA5A5);
    edges(2); chk("R8 deferred irq", irq_req, 0); chk("R8 data unchanged", data_in, 16'h1234);
    svc_active = 0;
    edges(2); chk("R8 before exit", irq_req, 0);
    edges(1); chk("R8 reraised", irq_req, 1); chk("R8 sel down", sel_resp, 0);
    edges(2);
    svc_active = 1;
    edges(3); chk("R8 new cc", cc_in, 7); chk("R8 new data", data_in, 16'hA5A5);
    strobe = 1; edges(3); strobe = 0; svc_active = 0;
    edges(4); chk("R7 after", sel_resp, 0);

    svc_active = 1;
    edges(6); chk("R4 no pending", sel_resp, 0);
    svc_active = 0; edges(4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule